// File: doc/BRIEF.md
# Memory Fill Command Engine

This block accelerates bulk memory initialisation for a character-and-graphics display. A host processor loads a small set of fill parameters (left column, top row, width, height and a fill value) into byte registers, then writes a command code. The engine walks the addressed region, issuing exactly one byte write per clock through its own write port, either into the character memory or into the three one-bit-per-pixel colour planes of the graphics memory. The memories themselves sit outside the block.

While it works, the engine raises a busy flag and a grant output that gives its own writes precedence over processor access to the memories. When it finishes it clears the command register back to zero, so software can poll either the busy bit or the command register. A dedicated abort code stops any operation at once.

Rectangles are walked row by row with the column advancing first; each row starts at `row * stride + column`, where the stride is the number of text columns for the character memory and one byte per eight pixels for the graphics memory.

Top module: `fill_engine`

## Requirements
- R1: After a synchronous active-low reset, `cmd_o` is 0x00, `status_o` is 0x00, `grant_o` is low and neither write enable is high.
- R2: Writing 0x01 to the command register (offset 5) fills every character address from 0 to `TXT_COLS*TXT_ROWS-1` with 0x20.
- R3: Command 0x02 fills the rectangle given by the registers at offset 0 (column), 1 (row), 2 (width), 3 (height) and 4 (fill value) in character memory; byte (c, r) of the rectangle goes to address `(row+r)*TXT_COLS + column + c`, columns advancing before rows, and no other address is written.
- R4: Command 0x04 writes 0x00 to all three planes at every graphics address from 0 to `(H_PIXELS/8)*V_LINES-1`.
- R5: Command 0x08 fills a graphics rectangle using stride `H_PIXELS/8`; each plane byte is 0xFF where its colour bit is 1 and 0x00 otherwise, with fill bit 2 driving `gfx_data_o[23:16]`, bit 1 `[15:8]` and bit 0 `[7:0]`.
- R6: An operation of width W and height H produces exactly W*H write cycles on consecutive clocks, and only the enable of the addressed memory is ever raised.
- R7: `status_o[7]` and `grant_o` go high on the clock after the command write is taken and stay high until the engine is idle again; no write occurs while they are low.
- R8: When an operation completes, the command register reads 0x00 and the engine is idle.
- R9: A width or height of zero, or a nonzero command code other than 0x01, 0x02, 0x04, 0x08 and 0xFF, completes through the busy sequence without any write and clears the command register.
- R10: Writing 0xFF to the command register returns the engine to idle on that clock edge from any state, stops all further writes, and leaves the command register at 0x00; issued while idle it has no other effect.
- R11: While busy, writes to the parameter registers and command writes other than 0xFF do not change the running operation or the command register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe from the host |
| reg_addr | input | 3 | Register offset: 0 column, 1 row, 2 width, 3 height, 4 fill, 5 command |
| reg_wdata | input | 8 | Register write data |
| cmd_o | output | 8 | Current command register contents |
| status_o | output | 8 | Status byte, bit 7 = busy, other bits zero |
| grant_o | output | 1 | High while the engine owns the memories |
| txt_we_o | output | 1 | Character memory write enable |
| gfx_we_o | output | 1 | Graphics memory write enable (all three planes) |
| wr_addr_o | output | ADDR_W | Write address for the enabled memory |
| txt_data_o | output | 8 | Character byte to write |
| gfx_data_o | output | 24 | Plane bytes: red [23:16], green [15:8], blue [7:0] |

## Verification
The bench builds the engine with an 8-by-4 character grid and a 32-pixel by 6-line graphics area (stride 4) and an 8-bit address. These small sizes let a full clear finish in a few dozen cycles, so the bench can hold a complete shadow copy of both memories, compare every byte after each command, and confirm that rectangle borders, row wrap at the stride and untouched bytes around a rectangle all behave, as well as timing an abort part-way through a clear.

// File: rtl/fill_pkg.sv
// Shared definitions for the memory fill engine: FSM states,
// register offsets and command codes.
package fill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2,
        ST_DONE  = 2'd3
    } fill_state_e;

    localparam logic [2:0] REG_COL    = 3'd0;
    localparam logic [2:0] REG_ROW    = 3'd1;
    localparam logic [2:0] REG_WIDTH  = 3'd2;
    localparam logic [2:0] REG_HEIGHT = 3'd3;
    localparam logic [2:0] REG_VALUE  = 3'd4;
    localparam logic [2:0] REG_CMD    = 3'd5;

    localparam logic [7:0] CMD_NONE      = 8'h00;
    localparam logic [7:0] CMD_TXT_ALL   = 8'h01;
    localparam logic [7:0] CMD_TXT_RECT  = 8'h02;
    localparam logic [7:0] CMD_GFX_ALL   = 8'h04;
    localparam logic [7:0] CMD_GFX_RECT  = 8'h08;
    localparam logic [7:0] CMD_ABORT     = 8'hFF;

    localparam logic [7:0] BLANK_CHAR    = 8'h20;

endpackage

// File: rtl/fill_param_regs.sv
// Host-facing parameter and command registers.
// Assumes: one register write per strobe; busy comes from the FSM.
// The command register ignores non-abort writes while busy, is
// cleared on completion and by the abort code.
module fill_param_regs
    import fill_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       busy,
    input  logic       clr_cmd,
    output logic [7:0] col_q,
    output logic [7:0] row_q,
    output logic [7:0] width_q,
    output logic [7:0] height_q,
    output logic [7:0] value_q,
    output logic [7:0] cmd_q,
    output logic       abort
);

    logic cmd_wr;

    // Decode command-register writes and the abort code.
    always_comb begin
        cmd_wr = reg_we && (reg_addr == REG_CMD);
        abort  = cmd_wr && (reg_wdata == CMD_ABORT);
    end

    // Parameter registers: always writable, only sampled at fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q    <= '0;
            row_q    <= '0;
            width_q  <= '0;
            height_q <= '0;
            value_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                REG_COL:    col_q    <= reg_wdata;
                REG_ROW:    row_q    <= reg_wdata;
                REG_WIDTH:  width_q  <= reg_wdata;
                REG_HEIGHT: height_q <= reg_wdata;
                REG_VALUE:  value_q  <= reg_wdata;
                default:    ;
            endcase
        end
    end

    // Command register: abort and completion clear it, idle writes load it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NONE;
        end else if (abort || clr_cmd) begin
            cmd_q <= CMD_NONE;
        end else if (cmd_wr && !busy) begin
            cmd_q <= reg_wdata;
        end
    end

    p_done_clears_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (cmd_q == CMD_NONE));

    p_abort_clears_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (cmd_q == CMD_NONE));

    p_busy_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !abort && !clr_cmd) |=> $stable(cmd_q));

endmodule

// File: rtl/fill_ctrl.sv
// Command sequencer: idle -> fetch -> execute -> done -> idle.
// Assumes: cmd never holds the abort code (the register clears it).
// In fetch it decodes the command into a target, origin, size and
// fill value; zero-sized or unknown work skips execute.
module fill_ctrl
    import fill_pkg::*;
#(
    parameter int TXT_COLS   = 80,
    parameter int TXT_ROWS   = 25,
    parameter int GFX_STRIDE = 80,
    parameter int V_LINES    = 200,
    parameter int DIM_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cmd,
    input  logic             abort,
    input  logic [7:0]       col_in,
    input  logic [7:0]       row_in,
    input  logic [7:0]       width_in,
    input  logic [7:0]       height_in,
    input  logic [7:0]       value_in,
    input  logic             last,
    output fill_state_e      state,
    output logic             busy,
    output logic             clr_cmd,
    output logic             load,
    output logic             step,
    output logic             tgt_gfx,
    output logic [DIM_W-1:0] ld_col,
    output logic [DIM_W-1:0] ld_row,
    output logic [DIM_W-1:0] ld_width,
    output logic [DIM_W-1:0] ld_height,
    output logic [7:0]       ld_value
);

    fill_state_e state_nx;
    logic        empty_job;

    // Translate the command code into the work description.
    always_comb begin
        tgt_gfx   = 1'b0;
        ld_col    = '0;
        ld_row    = '0;
        ld_width  = '0;
        ld_height = '0;
        ld_value  = 8'h00;
        case (cmd)
            CMD_TXT_ALL: begin
                ld_width  = DIM_W'(TXT_COLS);
                ld_height = DIM_W'(TXT_ROWS);
                ld_value  = BLANK_CHAR;
            end
            CMD_TXT_RECT: begin
                ld_col    = DIM_W'(col_in);
                ld_row    = DIM_W'(row_in);
                ld_width  = DIM_W'(width_in);
                ld_height = DIM_W'(height_in);
                ld_value  = value_in;
            end
            CMD_GFX_ALL: begin
                tgt_gfx   = 1'b1;
                ld_width  = DIM_W'(GFX_STRIDE);
                ld_height = DIM_W'(V_LINES);
            end
            CMD_GFX_RECT: begin
                tgt_gfx   = 1'b1;
                ld_col    = DIM_W'(col_in);
                ld_row    = DIM_W'(row_in);
                ld_width  = DIM_W'(width_in);
                ld_height = DIM_W'(height_in);
                ld_value  = {5'b0, value_in[2:0]};
            end
            default: ;
        endcase
        empty_job = (ld_width == '0) || (ld_height == '0);
    end

    // Next-state selection; abort overrides every state.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (cmd != CMD_NONE) state_nx = ST_FETCH;
            ST_FETCH: state_nx = empty_job ? ST_DONE : ST_EXEC;
            ST_EXEC:  if (last) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
        if (abort) state_nx = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Control strobes derived from the current state.
    always_comb begin
        busy    = (state != ST_IDLE);
        load    = (state == ST_FETCH) && !abort;
        step    = (state == ST_EXEC) && !abort;
        clr_cmd = (state == ST_DONE);
    end

    p_fetch_exits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && !abort) |=> (state == ST_EXEC || state == ST_DONE));

    p_done_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !abort) |=> (state == ST_IDLE));

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ST_IDLE));

endmodule

// File: rtl/fill_addr_gen.sv
// Rectangle walker: holds the current row start address and
// column/row counters. Columns advance first; each new row adds the
// target stride. Assumes load only with nonzero width and height
// when execute follows.
module fill_addr_gen #(
    parameter int TXT_COLS   = 80,
    parameter int GFX_STRIDE = 80,
    parameter int DIM_W      = 8,
    parameter int ADDR_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              tgt_gfx,
    input  logic [DIM_W-1:0]  ld_col,
    input  logic [DIM_W-1:0]  ld_row,
    input  logic [DIM_W-1:0]  ld_width,
    input  logic [DIM_W-1:0]  ld_height,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    logic [ADDR_W-1:0] row_start;
    logic [ADDR_W-1:0] stride_q;
    logic [ADDR_W-1:0] stride_sel;
    logic [DIM_W-1:0]  col_cnt;
    logic [DIM_W-1:0]  row_cnt;
    logic [DIM_W-1:0]  width_q;
    logic [DIM_W-1:0]  height_q;
    logic              row_end;

    // Stride choice and end-of-row / end-of-job detection.
    always_comb begin
        stride_sel = tgt_gfx ? ADDR_W'(GFX_STRIDE) : ADDR_W'(TXT_COLS);
        row_end    = (col_cnt == width_q - DIM_W'(1));
        last       = row_end && (row_cnt == height_q - DIM_W'(1));
        addr       = row_start + ADDR_W'(col_cnt);
    end

    // Counter and row-base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_start <= '0;
            stride_q  <= '0;
            col_cnt   <= '0;
            row_cnt   <= '0;
            width_q   <= '0;
            height_q  <= '0;
        end else if (load) begin
            row_start <= ADDR_W'(ld_row) * stride_sel + ADDR_W'(ld_col);
            stride_q  <= stride_sel;
            col_cnt   <= '0;
            row_cnt   <= '0;
            width_q   <= ld_width;
            height_q  <= ld_height;
        end else if (step) begin
            if (row_end) begin
                col_cnt   <= '0;
                row_cnt   <= row_cnt + DIM_W'(1);
                row_start <= row_start + stride_q;
            end else begin
                col_cnt   <= col_cnt + DIM_W'(1);
            end
        end
    end

    p_col_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (col_cnt < width_q && row_cnt < height_q));

endmodule

// File: rtl/fill_wr_port.sv
// Registered write port: latches target and fill value at fetch,
// then drives one write per execute cycle to the selected memory.
// Graphics colour bits expand to full plane bytes.
module fill_wr_port #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              tgt_gfx,
    input  logic [7:0]        ld_value,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              txt_we,
    output logic              gfx_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        txt_data,
    output logic [23:0]       gfx_data
);

    logic       tgt_q;
    logic [7:0] value_q;
    logic [23:0] planes;

    // Expand colour bits into per-plane bytes (red, green, blue).
    always_comb begin
        planes = {{8{value_q[2]}}, {8{value_q[1]}}, {8{value_q[0]}}};
    end

    // Latch job target and value at fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= 1'b0;
            value_q <= 8'h00;
        end else if (load) begin
            tgt_q   <= tgt_gfx;
            value_q <= ld_value;
        end
    end

    // Output registers for the memory write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txt_we   <= 1'b0;
            gfx_we   <= 1'b0;
            wr_addr  <= '0;
            txt_data <= 8'h00;
            gfx_data <= 24'h0;
        end else begin
            txt_we   <= step && !tgt_q;
            gfx_we   <= step && tgt_q;
            wr_addr  <= addr_in;
            txt_data <= value_q;
            gfx_data <= planes;
        end
    end

    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(txt_we && gfx_we));

endmodule

// File: rtl/fill_engine.sv
// Memory fill engine top: host registers, sequencer, rectangle
// walker and registered write port. Assumes the surrounding
// arbiter gives the engine the memories whenever grant_o is high.
module fill_engine
    import fill_pkg::*;
#(
    parameter int TXT_COLS = 80,
    parameter int TXT_ROWS = 25,
    parameter int H_PIXELS = 640,
    parameter int V_LINES  = 200,
    parameter int ADDR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        cmd_o,
    output logic [7:0]        status_o,
    output logic              grant_o,
    output logic              txt_we_o,
    output logic              gfx_we_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        txt_data_o,
    output logic [23:0]       gfx_data_o
);

    localparam int GFX_STRIDE = H_PIXELS / 8;
    localparam int MAX_A      = (TXT_COLS > TXT_ROWS) ? TXT_COLS : TXT_ROWS;
    localparam int MAX_B      = (GFX_STRIDE > V_LINES) ? GFX_STRIDE : V_LINES;
    localparam int MAX_DIM    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int DIM_NEED   = $clog2(MAX_DIM + 1);
    localparam int DIM_W      = (DIM_NEED > 8) ? DIM_NEED : 8;

    logic [7:0]        col_q, row_q, width_q, height_q, value_q, cmd_q;
    logic              abort, busy, clr_cmd, load, step, tgt_gfx, last;
    fill_state_e       state;
    logic [DIM_W-1:0]  ld_col, ld_row, ld_width, ld_height;
    logic [7:0]        ld_value;
    logic [ADDR_W-1:0] walk_addr;

    fill_param_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .clr_cmd   (clr_cmd),
        .col_q     (col_q),
        .row_q     (row_q),
        .width_q   (width_q),
        .height_q  (height_q),
        .value_q   (value_q),
        .cmd_q     (cmd_q),
        .abort     (abort)
    );

    fill_ctrl #(
        .TXT_COLS   (TXT_COLS),
        .TXT_ROWS   (TXT_ROWS),
        .GFX_STRIDE (GFX_STRIDE),
        .V_LINES    (V_LINES),
        .DIM_W      (DIM_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd_q),
        .abort     (abort),
        .col_in    (col_q),
        .row_in    (row_q),
        .width_in  (width_q),
        .height_in (height_q),
        .value_in  (value_q),
        .last      (last),
        .state     (state),
        .busy      (busy),
        .clr_cmd   (clr_cmd),
        .load      (load),
        .step      (step),
        .tgt_gfx   (tgt_gfx),
        .ld_col    (ld_col),
        .ld_row    (ld_row),
        .ld_width  (ld_width),
        .ld_height (ld_height),
        .ld_value  (ld_value)
    );

    fill_addr_gen #(
        .TXT_COLS   (TXT_COLS),
        .GFX_STRIDE (GFX_STRIDE),
        .DIM_W      (DIM_W),
        .ADDR_W     (ADDR_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .tgt_gfx   (tgt_gfx),
        .ld_col    (ld_col),
        .ld_row    (ld_row),
        .ld_width  (ld_width),
        .ld_height (ld_height),
        .addr      (walk_addr),
        .last      (last)
    );

    fill_wr_port #(
        .ADDR_W (ADDR_W)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .tgt_gfx  (tgt_gfx),
        .ld_value (ld_value),
        .addr_in  (walk_addr),
        .txt_we   (txt_we_o),
        .gfx_we   (gfx_we_o),
        .wr_addr  (wr_addr_o),
        .txt_data (txt_data_o),
        .gfx_data (gfx_data_o)
    );

    // Host-visible status and arbitration outputs.
    always_comb begin
        cmd_o    = cmd_q;
        status_o = {busy, 7'b0};
        grant_o  = busy;
    end

    p_write_under_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txt_we_o || gfx_we_o) |-> grant_o);

    p_abort_silences_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !(txt_we_o || gfx_we_o || grant_o));

    p_idle_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !(txt_we_o || gfx_we_o));

endmodule

// File: tb/fill_engine_bench.sv
// Directed bench for the memory fill engine with a small geometry.
module fill_engine_bench;

    localparam int COLS   = 8;
    localparam int ROWS   = 4;
    localparam int HPIX   = 32;
    localparam int VLN    = 6;
    localparam int GSTR   = HPIX / 8;
    localparam int TDEPTH = COLS * ROWS;
    localparam int GDEPTH = GSTR * VLN;
    localparam int AW     = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    cmd_o, status_o;
    logic          grant_o, txt_we_o, gfx_we_o;
    logic [AW-1:0] wr_addr_o;
    logic [7:0]    txt_data_o;
    logic [23:0]   gfx_data_o;

    int checks = 0;
    int errors = 0;

    logic [7:0]  tmem [TDEPTH];
    logic [23:0] gmem [GDEPTH];
    int          tcnt, gcnt, cyc, first_cyc, last_cyc, bad_addr;
    int          alog [64];

    fill_engine #(
        .TXT_COLS (COLS),
        .TXT_ROWS (ROWS),
        .H_PIXELS (HPIX),
        .V_LINES  (VLN),
        .ADDR_W   (AW)
    ) u_fill_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .cmd_o      (cmd_o),
        .status_o   (status_o),
        .grant_o    (grant_o),
        .txt_we_o   (txt_we_o),
        .gfx_we_o   (gfx_we_o),
        .wr_addr_o  (wr_addr_o),
        .txt_data_o (txt_data_o),
        .gfx_data_o (gfx_data_o)
    );

    always #10 clk = ~clk;

    // Shadow memories: capture writes a quarter period after the edge.
    always @(posedge clk) begin
        #5;
        cyc++;
        if (txt_we_o || gfx_we_o) begin
            if (tcnt + gcnt < 64) alog[tcnt + gcnt] = int'(wr_addr_o);
            if (tcnt + gcnt == 0) first_cyc = cyc;
            last_cyc = cyc;
        end
        if (txt_we_o) begin
            if (int'(wr_addr_o) < TDEPTH) tmem[wr_addr_o] = txt_data_o;
            else bad_addr++;
            tcnt++;
        end
        if (gfx_we_o) begin
            if (int'(wr_addr_o) < GDEPTH) gmem[wr_addr_o] = gfx_data_o;
            else bad_addr++;
            gcnt++;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preset();
        for (int i = 0; i < TDEPTH; i++) tmem[i] = 8'hEE;
        for (int i = 0; i < GDEPTH; i++) gmem[i] = 24'hEEEEEE;
        tcnt = 0; gcnt = 0; bad_addr = 0; first_cyc = 0; last_cyc = -1;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_rect(input int c, input int r, input int w, input int h, input int v);
        wr_reg(3'd0, 8'(c)); wr_reg(3'd1, 8'(r));
        wr_reg(3'd2, 8'(w)); wr_reg(3'd3, 8'(h));
        wr_reg(3'd4, 8'(v));
    endtask

    // Issue a command, check busy/grant rise, wait for completion.
    task automatic run_cmd(input logic [7:0] code, input string req);
        int n;
        wr_reg(3'd5, code);
        @(negedge clk);
        chk(status_o[7] && grant_o, {req, " R7 busy+grant after command"}, {status_o[7], grant_o}, 2'b11);
        n = 0;
        while (status_o[7] && n < 2000) begin @(negedge clk); n++; end
        chk(!grant_o, "R7 grant drops with busy", grant_o, 0);
        chk(cmd_o == 8'h00, {req, " R8 command cleared"}, cmd_o, 0);
    endtask

    task automatic t_reset();
        chk(cmd_o == 8'h00 && status_o == 8'h00, "R1 reset registers", {cmd_o, status_o}, 0);
        chk(!grant_o && !txt_we_o && !gfx_we_o, "R1 reset outputs", {grant_o, txt_we_o, gfx_we_o}, 0);
    endtask

    task automatic t_text_clear();
        int mis = 0;
        preset();
        run_cmd(8'h01, "R2");
        for (int i = 0; i < TDEPTH; i++) if (tmem[i] != 8'h20) mis++;
        chk(mis == 0, "R2 every text byte is 0x20", mis, 0);
        chk(tcnt == TDEPTH && gcnt == 0, "R6 text clear write count", tcnt, TDEPTH);
        chk(last_cyc - first_cyc + 1 == tcnt, "R6 writes on consecutive clocks", last_cyc - first_cyc + 1, tcnt);
    endtask

    task automatic t_text_rect();
        int mis = 0;
        int exp_order [6] = '{10, 11, 12, 18, 19, 20};
        preset();
        set_rect(2, 1, 3, 2, 8'h41);
        run_cmd(8'h02, "R3");
        for (int i = 0; i < TDEPTH; i++) begin
            logic in_r;
            in_r = (i / COLS >= 1) && (i / COLS < 3) && (i % COLS >= 2) && (i % COLS < 5);
            if (tmem[i] != (in_r ? 8'h41 : 8'hEE)) mis++;
        end
        chk(mis == 0, "R3 text rectangle contents", mis, 0);
        for (int k = 0; k < 6; k++)
            chk(alog[k] == exp_order[k], "R3 column-first order", alog[k], exp_order[k]);
        chk(tcnt == 6 && bad_addr == 0, "R6 text rect write count", tcnt, 6);
    endtask

    task automatic t_gfx_clear();
        int mis = 0;
        preset();
        run_cmd(8'h04, "R4");
        for (int i = 0; i < GDEPTH; i++) if (gmem[i] != 24'h0) mis++;
        chk(mis == 0, "R4 all planes zero", mis, 0);
        chk(gcnt == GDEPTH && tcnt == 0, "R6 graphics clear count", gcnt, GDEPTH);
    endtask

    task automatic t_gfx_rect();
        int mis = 0;
        preset();
        set_rect(1, 2, 2, 3, 8'hF5);
        run_cmd(8'h08, "R5");
        for (int i = 0; i < GDEPTH; i++) begin
            logic in_r;
            in_r = (i / GSTR >= 2) && (i / GSTR < 5) && (i % GSTR >= 1) && (i % GSTR < 3);
            if (gmem[i] != (in_r ? 24'hFF00FF : 24'hEEEEEE)) mis++;
        end
        chk(mis == 0, "R5 plane bytes from colour 5", mis, 0);
        chk(gcnt == 6 && tcnt == 0, "R6 graphics rect count", gcnt, 6);
        chk(alog[2] == 13, "R5 graphics stride row wrap", alog[2], 13);
    endtask

    task automatic t_empty();
        preset();
        set_rect(0, 0, 0, 2, 8'h33);
        run_cmd(8'h02, "R9 zero width");
        set_rect(0, 0, 2, 0, 8'h03);
        run_cmd(8'h08, "R9 zero height");
        run_cmd(8'h10, "R9 unknown code");
        chk(tcnt + gcnt == 0, "R9 no writes for empty or unknown work", tcnt + gcnt, 0);
    endtask

    task automatic t_abort();
        int snap;
        preset();
        wr_reg(3'd5, 8'h01);
        repeat (6) @(negedge clk);
        wr_reg(3'd5, 8'hFF);
        chk(!status_o[7] && !grant_o, "R10 idle right after abort", status_o[7], 0);
        chk(cmd_o == 8'h00, "R10 command cleared by abort", cmd_o, 0);
        snap = tcnt;
        repeat (5) @(negedge clk);
        chk(tcnt == snap && snap > 0 && snap < TDEPTH, "R10 writes stop", tcnt, snap);
        wr_reg(3'd5, 8'hFF);
        @(negedge clk);
        chk(!status_o[7] && cmd_o == 8'h00 && tcnt == snap, "R10 idle abort harmless", cmd_o, 0);
    endtask

    task automatic t_busy_writes();
        int mis = 0;
        int n = 0;
        preset();
        set_rect(0, 0, COLS, ROWS, 8'h55);
        wr_reg(3'd5, 8'h02);
        repeat (4) @(negedge clk);
        wr_reg(3'd4, 8'h66);
        wr_reg(3'd2, 8'h01);
        wr_reg(3'd5, 8'h04);
        chk(cmd_o == 8'h02, "R11 command unchanged while busy", cmd_o, 8'h02);
        while (status_o[7] && n < 2000) begin @(negedge clk); n++; end
        for (int i = 0; i < TDEPTH; i++) if (tmem[i] != 8'h55) mis++;
        chk(mis == 0 && gcnt == 0, "R11 running fill unaffected", mis, 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL R7 watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_text_clear();
        t_text_rect();
        t_gfx_clear();
        t_gfx_rect();
        t_empty();
        t_abort();
        t_busy_writes();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule